// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block is the digital core of the feedback path in a fractional-N frequency synthesizer. It runs on the divided RF clock and splits that clock into divisions whose length changes from one division to the next. The average ratio equals an integer part plus a fraction over a power-of-two modulus. A third-order noise-shaping modulator sets the length of each division and steps once per division. One output pulse marks the last cycle of each division. The pulse feeds the phase detector, which is not part of this block.

The integer and fractional control words arrive as parallel inputs. A load strobe captures them into a pending copy. That copy becomes active only at the next division boundary, so no division ever mixes an old integer with a new fraction. The modulator adds a fixed input LSB, so its accumulators see `2*FRAC+1` over a modulus of `2^(FRAC_W+1)`. This produces a built-in half-LSB offset: the mean ratio is INT + (FRAC+0.5)/2^FRAC_W. Every ratio is saturated to the legal range. The block flags a division whose ratio was saturated, and it flags an active integer word below the legal minimum.

Top module: `fracn_fb_divider`

## Requirements
- R1: A synchronous reset clears all modulator accumulators and delay taps to zero. It makes the values on `int_val`/`frac_val` active, drops any pending load and sets `div_ratio` to MIN_RATIO with `ratio_clamped` low. On the first clock after reset is released, `div_pulse` is high.
- R2: Each division lasts exactly `div_ratio` clocks. `div_pulse` is high on the last clock of each division only, and the next division starts on the following clock with no idle cycle.
- R3: At each boundary, the next ratio is the active INT plus a modulator offset y = c1 + (c2 - c2') + (c3 - 2·c3' + c3''). Here c1..c3 are the carries of three cascaded accumulators of FRAC_W+1 bits. The first accumulator adds `{FRAC,1}`, each later one adds the previous accumulator's new sum, and a prime marks the value from one step earlier. y lies in -3..+4.
- R4: Starting from reset, the sum of the first 2^(FRAC_W+1) ratios equals 2^(FRAC_W+1)·INT + 2·FRAC + 1, within ±3 clocks.
- R5: A ratio below MIN_RATIO is replaced by MIN_RATIO, and one above 2^INT_W−1 is replaced by 2^INT_W−1. `ratio_clamped` is high for exactly the divisions whose ratio was replaced.
- R6: `int_err` is high whenever the active integer word is below MIN_RATIO.
- R7: A load strobe captures `int_val`/`frac_val`. The active values, and so the current division, change only at the next boundary. When several strobes precede a boundary, the last one wins.
- R8: The modulator steps once per division, so its offset sequence does not depend on the integer word or on division length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided RF clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_stb | input | 1 | Capture strobe for the control words |
| int_val | input | INT_W | Integer part of the ratio |
| frac_val | input | FRAC_W | Fractional numerator |
| div_pulse | output | 1 | High on the last clock of each division |
| div_ratio | output | INT_W | Length of the current division |
| ratio_clamped | output | 1 | Current division ratio was saturated |
| int_err | output | 1 | Active integer word below the legal minimum |

## Verification
The bench builds the block with INT_W=12, MIN_RATIO=23 and a 10-bit fraction, which gives an 11-bit accumulator. One full modulator period is then 2048 divisions, so the exact long-run average, half-LSB offset included, can be checked from reset within the cycle budget. The 12-bit integer width is kept, which puts both saturation limits, 23 and 4095, within reach with real modulator noise on top. The pending/active hand-off is exercised with strobes placed in the middle of a division.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
   // number of cascaded first-order stages (third-order noise shaping)
   localparam int STAGES = 3;
   // signed offset range -3..+4 needs four bits
   localparam int OFF_W  = 4;
   typedef logic signed [OFF_W-1:0] mash_off_t;
endpackage

// File: rtl/fracn_accum.sv
module fracn_accum #(
   parameter int W = 26
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step,
   input  logic [W-1:0] addend,
   output logic [W-1:0] sum_nxt,
   output logic         carry
);
   logic [W-1:0] acc_q;
   logic [W:0]   full;

   initial begin
      assert (W >= 2) else $error("fracn_accum: W must be at least 2");
   end

   assign full    = {1'b0, acc_q} + {1'b0, addend};
   assign sum_nxt = full[W-1:0];
   assign carry   = full[W];

   always_ff @(posedge clk) begin
      if (rst)       acc_q <= '0;
      else if (step) acc_q <= sum_nxt;
   end

   // state moves only on a modulator step
   assert_acc_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(acc_q));
endmodule

// File: rtl/fracn_mash.sv
module fracn_mash
   import fracn_pkg::*;
#(
   parameter int FRAC_W = 25,
   localparam int ACC_W = FRAC_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   input  logic [FRAC_W-1:0] frac,
   output mash_off_t         offset
);
   logic [ACC_W-1:0] addend [STAGES];
   logic [ACC_W-1:0] sums   [STAGES];
   logic [STAGES-1:0] cy;
   logic c2_d, c3_d, c3_dd;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
         // forced LSB gives the half-LSB fractional offset
         assign addend[g] = {frac, 1'b1};
      end else begin : g_tail
         assign addend[g] = sums[g-1];
      end
      fracn_accum #(.W(ACC_W)) u_acc (
         .clk    (clk),
         .rst    (rst),
         .step   (step),
         .addend (addend[g]),
         .sum_nxt(sums[g]),
         .carry  (cy[g])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         c2_d  <= 1'b0;
         c3_d  <= 1'b0;
         c3_dd <= 1'b0;
      end else if (step) begin
         c2_d  <= cy[1];
         c3_d  <= cy[2];
         c3_dd <= c3_d;
      end
   end

   always_comb begin
      offset = mash_off_t'({3'b000, cy[0]})
             + mash_off_t'({3'b000, cy[1]}) - mash_off_t'({3'b000, c2_d})
             + mash_off_t'({3'b000, cy[2]}) - mash_off_t'({2'b00, c3_d, 1'b0})
             + mash_off_t'({3'b000, c3_dd});
   end

   // delay taps frozen between steps
   assert_tap_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable({c2_d, c3_d, c3_dd}));
endmodule

// File: rtl/fracn_div_counter.sv
module fracn_div_counter #(
   parameter int CW       = 12,
   parameter int MIN_LOAD = 23
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] load_val,
   output logic          term
);
   logic [CW-1:0] cnt;

   initial begin
      assert (MIN_LOAD >= 2) else $error("fracn_div_counter: MIN_LOAD must be >= 2");
   end

   assign term = (cnt == '0);

   always_ff @(posedge clk) begin
      if (rst)       cnt <= '0;
      else if (term) cnt <= load_val - CW'(1);
      else           cnt <= cnt - CW'(1);
   end

   // a boundary is never followed by another at once
   assert_no_double_R2: assert property (@(posedge clk) disable iff (rst)
      term |=> !term);
endmodule

// File: rtl/fracn_fb_divider.sv
module fracn_fb_divider
   import fracn_pkg::*;
#(
   parameter int INT_W     = 12,
   parameter int FRAC_W    = 25,
   parameter int MIN_RATIO = 23
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld_stb,
   input  logic [INT_W-1:0]  int_val,
   input  logic [FRAC_W-1:0] frac_val,
   output logic              div_pulse,
   output logic [INT_W-1:0]  div_ratio,
   output logic              ratio_clamped,
   output logic              int_err
);
   localparam int SW = INT_W + 2;
   localparam logic signed [SW-1:0] RAW_MIN = SW'(MIN_RATIO);
   localparam logic signed [SW-1:0] RAW_MAX = SW'((1 << INT_W) - 1);
   localparam logic [INT_W-1:0] MIN_L = INT_W'(MIN_RATIO);
   localparam logic [INT_W-1:0] MAX_L = '1;

   initial begin
      assert (INT_W >= 6 && INT_W <= 24) else $error("INT_W out of range");
      assert (FRAC_W >= 2 && FRAC_W <= 29) else $error("FRAC_W out of range");
      assert (MIN_RATIO >= 8 && MIN_RATIO < (1 << INT_W) - 4)
         else $error("MIN_RATIO out of range");
   end

   logic [INT_W-1:0]  act_int, pend_int, sel_int, nxt_ratio;
   logic [FRAC_W-1:0] act_frac, pend_frac, sel_frac;
   logic              pend_v, nxt_clamp, term;
   logic signed [SW-1:0] raw;
   mash_off_t         off;

   // pending words replace the active ones only at a boundary
   assign sel_int  = pend_v ? pend_int  : act_int;
   assign sel_frac = pend_v ? pend_frac : act_frac;

   fracn_mash #(.FRAC_W(FRAC_W)) u_mash (
      .clk   (clk),
      .rst   (rst),
      .step  (term),
      .frac  (sel_frac),
      .offset(off)
   );

   always_comb begin
      raw = $signed({2'b00, sel_int}) + SW'(off);
      nxt_clamp = 1'b0;
      nxt_ratio = raw[INT_W-1:0];
      if (raw < RAW_MIN) begin
         nxt_ratio = MIN_L;
         nxt_clamp = 1'b1;
      end else if (raw > RAW_MAX) begin
         nxt_ratio = MAX_L;
         nxt_clamp = 1'b1;
      end
   end

   fracn_div_counter #(.CW(INT_W), .MIN_LOAD(MIN_RATIO)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .load_val(nxt_ratio),
      .term    (term)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         act_int       <= int_val;
         act_frac      <= frac_val;
         pend_int      <= '0;
         pend_frac     <= '0;
         pend_v        <= 1'b0;
         div_ratio     <= MIN_L;
         ratio_clamped <= 1'b0;
      end else begin
         if (term) begin
            act_int       <= sel_int;
            act_frac      <= sel_frac;
            div_ratio     <= nxt_ratio;
            ratio_clamped <= nxt_clamp;
         end
         if (ld_stb) begin
            pend_int  <= int_val;
            pend_frac <= frac_val;
            pend_v    <= 1'b1;
         end else if (term) begin
            pend_v    <= 1'b0;
         end
      end
   end

   assign div_pulse = term;
   assign int_err   = (act_int < MIN_L);

   assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !div_pulse |=> $stable(act_int) && $stable(act_frac) && $stable(div_ratio));

   assert_ratio_legal_R5: assert property (@(posedge clk) disable iff (rst)
      div_ratio >= MIN_L);

   assert_clamp_edge_R5: assert property (@(posedge clk) disable iff (rst)
      ratio_clamped |-> (div_ratio == MIN_L || div_ratio == MAX_L));

   assert_ratio_window_R3: assert property (@(posedge clk) disable iff (rst)
      div_pulse |=> ratio_clamped ||
         (({2'b00, div_ratio} + SW'(3) >= {2'b00, $past(sel_int)}) &&
          ({2'b00, div_ratio} <= {2'b00, $past(sel_int)} + SW'(4))));
endmodule

// File: tb/tb_fracn_fb_divider.sv
module tb_fracn_fb_divider;
   localparam int IW   = 12;
   localparam int FW   = 10;
   localparam int AW   = FW + 1;
   localparam int M    = 1 << AW;
   localparam int MINR = 23;
   localparam int MAXR = (1 << IW) - 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ld_stb = 1'b0;
   logic [IW-1:0] int_val = 12'd30;
   logic [FW-1:0] frac_val = '0;
   logic div_pulse, ratio_clamped, int_err;
   logic [IW-1:0] div_ratio;

   always #10 clk = ~clk;

   fracn_fb_divider #(.INT_W(IW), .FRAC_W(FW), .MIN_RATIO(MINR)) dut (
      .clk(clk), .rst(rst), .ld_stb(ld_stb), .int_val(int_val),
      .frac_val(frac_val), .div_pulse(div_pulse), .div_ratio(div_ratio),
      .ratio_clamped(ratio_clamped), .int_err(int_err)
   );

   int checks = 0, fails = 0;
   // reference state
   int m_a1, m_a2, m_a3, m_c2p, m_c3p, m_c3pp, m_cnt;
   int m_ai, m_af, m_pi, m_pf, m_pv, m_ratio, m_clamp;
   bit m_valid = 0;
   // last sampled outputs
   int s_pulse, s_ratio, s_clamp, s_err;
   int cyc_idx = 0, pcount = 0, clamp_seen = 0;

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc_idx);
      end
   endtask

   task automatic model_step(bit r, bit ld, int iv, int fv);
      bit term;
      int si, sf, s1, s2, s3, c1, c2, c3, y, n;
      if (r) begin
         m_a1 = 0; m_a2 = 0; m_a3 = 0; m_c2p = 0; m_c3p = 0; m_c3pp = 0;
         m_cnt = 0; m_ai = iv; m_af = fv; m_pv = 0; m_pi = 0; m_pf = 0;
         m_ratio = MINR; m_clamp = 0;
         return;
      end
      term = (m_cnt == 0);
      if (term) begin
         si = m_pv ? m_pi : m_ai;
         sf = m_pv ? m_pf : m_af;
         s1 = m_a1 + 2 * sf + 1; c1 = s1 / M; s1 = s1 % M;
         s2 = m_a2 + s1;         c2 = s2 / M; s2 = s2 % M;
         s3 = m_a3 + s2;         c3 = s3 / M; s3 = s3 % M;
         y = c1 + c2 - m_c2p + c3 - 2 * m_c3p + m_c3pp;
         m_a1 = s1; m_a2 = s2; m_a3 = s3;
         m_c3pp = m_c3p; m_c3p = c3; m_c2p = c2;
         n = si + y; m_clamp = 0;
         if (n < MINR) begin n = MINR; m_clamp = 1; end
         else if (n > MAXR) begin n = MAXR; m_clamp = 1; end
         m_ratio = n; m_cnt = n - 1; m_ai = si; m_af = sf;
      end else begin
         m_cnt--;
      end
      if (ld) begin m_pi = iv; m_pf = fv; m_pv = 1; end
      else if (term) m_pv = 0;
   endtask

   task automatic cyc(bit r, bit ld, int iv, int fv);
      @(negedge clk);
      cyc_idx++;
      s_pulse = int'(div_pulse); s_ratio = int'(div_ratio);
      s_clamp = int'(ratio_clamped); s_err = int'(int_err);
      if (s_pulse == 1) pcount++;
      if (s_clamp == 1) clamp_seen++;
      if (m_valid && !rst) begin
         chk(s_pulse == int'(m_cnt == 0), "R2 div_pulse", s_pulse, int'(m_cnt == 0));
         chk(s_ratio == m_ratio, "R3 div_ratio", s_ratio, m_ratio);
         chk(s_clamp == m_clamp, "R5 ratio_clamped", s_clamp, m_clamp);
         chk(s_err == int'(m_ai < MINR), "R6 int_err", s_err, int'(m_ai < MINR));
      end
      rst = r; ld_stb = ld; int_val = IW'(iv); frac_val = FW'(fv);
      model_step(r, ld, iv, fv);
      m_valid = 1;
   endtask

   task automatic do_reset(int iv, int fv);
      cyc(1, 0, iv, fv);
      cyc(1, 0, iv, fv);
   endtask

   // run until the next boundary has been seen, then one more cycle
   task automatic to_next_ratio(int iv, int fv);
      do cyc(0, 0, iv, fv); while (s_pulse != 1);
      cyc(0, 0, iv, fv);
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_idx, 190000);
      finish_run();
   end

   initial begin
      int t0, t1, k, first_p;
      int offa [20];
      int offb [20];
      // R1: reset state and first boundary
      do_reset(30, 0);
      cyc(0, 0, 30, 0);
      chk(s_pulse == 1, "R1 first pulse", s_pulse, 1);
      chk(s_ratio == MINR, "R1 reset ratio", s_ratio, MINR);
      chk(s_clamp == 0, "R1 reset clamp", s_clamp, 0);
      chk(s_err == 0, "R1 reset err", s_err, 0);

      // R4: long-run average, FRAC = 0 leaves only the half-LSB offset
      do_reset(30, 0);
      pcount = 0; t0 = 0; t1 = 0;
      k = M;
      while (pcount < k + 1) begin
         first_p = pcount;
         cyc(0, 0, 30, 0);
         if (pcount == 1 && first_p == 0) t0 = cyc_idx;
         if (pcount == k + 1) t1 = cyc_idx;
      end
      chk((t1 - t0) >= k * 30 + 1 - 3 && (t1 - t0) <= k * 30 + 1 + 3,
          "R4 average FRAC=0", t1 - t0, k * 30 + 1);

      // R4 again with a nonzero fraction
      do_reset(40, 333);
      pcount = 0; t0 = 0; t1 = 0;
      while (pcount < 257) begin
         first_p = pcount;
         cyc(0, 0, 40, 333);
         if (pcount == 1 && first_p == 0) t0 = cyc_idx;
         if (pcount == 257) t1 = cyc_idx;
      end
      chk((t1 - t0) >= 256 * 40 + (256 * 667) / M - 4 &&
          (t1 - t0) <= 256 * 40 + (256 * 667) / M + 4,
          "R4 partial average", t1 - t0, 256 * 40 + (256 * 667) / M);

      // R8: offset sequence independent of the integer word
      do_reset(40, 700);
      for (int i = 0; i < 20; i++) begin
         to_next_ratio(40, 700);
         offa[i] = s_ratio - 40;
      end
      do_reset(200, 700);
      for (int i = 0; i < 20; i++) begin
         to_next_ratio(200, 700);
         offb[i] = s_ratio - 200;
      end
      for (int i = 0; i < 20; i++)
         chk(offa[i] == offb[i] && offa[i] >= -3 && offa[i] <= 4,
             "R8 offset sequence", offb[i], offa[i]);

      // R7: mid-division load takes effect only at the boundary
      do_reset(100, 0);
      to_next_ratio(100, 0);
      repeat (5) cyc(0, 0, 100, 0);
      cyc(0, 1, 60, 0);
      repeat (3) cyc(0, 0, 60, 0);
      chk(s_ratio >= 97 && s_ratio <= 104, "R7 current division kept", s_ratio, 100);
      to_next_ratio(60, 0);
      chk(s_ratio >= 57 && s_ratio <= 64, "R7 new word applied", s_ratio, 60);
      // R7: last of two strobes wins
      repeat (4) cyc(0, 0, 60, 0);
      cyc(0, 1, 50, 0);
      cyc(0, 0, 50, 0);
      cyc(0, 1, 70, 0);
      to_next_ratio(70, 0);
      chk(s_ratio >= 67 && s_ratio <= 74, "R7 last strobe wins", s_ratio, 70);

      // R5: saturation at the bottom
      clamp_seen = 0;
      do_reset(MINR, (1 << FW) / 3);
      repeat (3000) cyc(0, 0, MINR, (1 << FW) / 3);
      chk(clamp_seen > 0, "R5 low clamp observed", clamp_seen, 1);
      // R5: saturation at the top
      clamp_seen = 0;
      do_reset(MAXR, (1 << FW) - 1);
      for (int i = 0; i < 6; i++) to_next_ratio(MAXR, (1 << FW) - 1);
      chk(clamp_seen > 0, "R5 high clamp observed", clamp_seen, 1);

      // R6: illegal integer word
      do_reset(10, 0);
      cyc(0, 0, 10, 0);
      chk(s_err == 1, "R6 int_err set", s_err, 1);
      to_next_ratio(10, 0);
      chk(s_ratio == MINR, "R6 ratio held at minimum", s_ratio, MINR);
      cyc(0, 1, 30, 0);
      to_next_ratio(30, 0);
      chk(s_err == 0, "R6 int_err cleared", s_err, 0);

      finish_run();
   end
endmodule